// File: doc/BRIEF.md
# Read-Cycle Parallel-to-Serial Tag Reader

This block accepts a set of four identifiers, already sorted, that arrive in parallel once per read cycle. It emits them one per system clock on a single output bus, with the smallest first. A read cycle is four system clocks long. The block counts those clocks with its own 2-bit select generator. The count is a slot index that runs 0, 1, 2, 3 and then wraps. This count is aligned to the divided tag clock and steers the output multiplexer.

The upstream sorter presents a set on `id_set_i` and raises `load_i` during the last slot of a read cycle (slot 3). At that edge the four holding registers capture the set. Over the next four clocks the output shows field 0, then 1, 2 and 3. The bus carries field k in bits [8k+7:8k], and field 0 is the smallest identifier. The block does not check the order; it emits whatever order the sorter supplies. If the sorter raises the strobe at the end of every read cycle, the sets leave back to back with no idle clock between them.

Top module: `tag_serializer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next state is: `ser_vld_o` = 0, `slot_o` = 0, and all holding registers = 0, so `ser_id_o` reads 0.
- R2: Out of reset, `slot_o` advances by one on every clock and wraps from 3 to 0. The first clock after reset is released moves it from 0 to 1.
- R3: `load_i` is sampled only at the edge that ends slot 3. At any other slot, `load_i` and `id_set_i` have no effect on the output.
- R4: After a capture, the output in slot k of the following read cycle equals field k of the captured `id_set_i`, where field k is bits [8k+7:8k]. One field is shown per clock, field 0 first.
- R5: `ser_vld_o` changes only on the edge into slot 0. It becomes 1 if `load_i` was high at that edge and 0 otherwise.
- R6: With sets {0x03, 0x0C, 0x18, 0x24} and then {0x04, 0x10, 0x20, 0x30} loaded at two consecutive wraps, the output carries those eight values in that order on eight consecutive clocks.
- R7: Changes on `id_set_i` during slots 0 to 2, or during slot 3 without `load_i`, leave the set being emitted unchanged.
- R8: At a wrap without `load_i`, the holding registers keep their contents. The next read cycle repeats the previous set with `ser_vld_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | Load strobe, taken at the end of slot 3 |
| id_set_i | input | 32 | Four sorted identifiers; field k in bits [8k+7:8k] |
| ser_id_o | output | 8 | Serial identifier of the current slot |
| ser_vld_o | output | 1 | Current read cycle carries a freshly loaded set |
| slot_o | output | 2 | Current slot index, equal to the rank being emitted |

## Verification
The assertions assume that `load_i` and `id_set_i` change only away from the rising clock edge. They also assume that the sorter may hold the strobe high at any slot, so a strobe outside slot 3 is expected and must be ignored. The bench drives every input at the falling edge. It toggles `load_i` in slots 0 to 2 and replaces `id_set_i` with scrambled values there, so R3 and R7 are exercised on every read cycle. At the wraps it drops the strobe on a fixed schedule, so both outcomes of R5 and R8 occur many times across several hundred clocks.

// File: rtl/tag_serializer_pkg.sv
// Package: shared defaults for the read-cycle serialiser.
// Assumes: a read cycle holds TS_SLOTS slots; identifiers are TS_ID_W bits.
package tag_serializer_pkg;
    parameter int unsigned TS_ID_W  = 8;
    parameter int unsigned TS_SLOTS = 4;
endpackage

// File: rtl/tag_sel_gen.sv
// Module: tag_sel_gen
// Select generator. A free-running slot counter aligned to the read cycle.
// Assumes: SLOTS >= 2; reset forces slot 0.
module tag_sel_gen #(
    parameter int unsigned SLOTS = tag_serializer_pkg::TS_SLOTS,
    localparam int unsigned SEL_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [SEL_W-1:0] sel_q,
    output logic             wrap_o
);
    localparam logic [SEL_W-1:0] LAST = SEL_W'(SLOTS - 1);

    // last slot of the read cycle
    assign wrap_o = (sel_q == LAST);

    // count slots, wrap at the end of the read cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (wrap_o)
            sel_q <= '0;
        else
            sel_q <= sel_q + 1'b1;
    end
endmodule

// File: rtl/tag_hold_bank.sv
// Module: tag_hold_bank
// One holding register per slot. All registers capture together on cap_i.
// Assumes: cap_i is qualified by the caller (load strobe at the wrap slot).
module tag_hold_bank #(
    parameter int unsigned ID_W  = tag_serializer_pkg::TS_ID_W,
    parameter int unsigned SLOTS = tag_serializer_pkg::TS_SLOTS,
    localparam int unsigned TOTAL_W = ID_W * SLOTS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap_i,
    input  logic [TOTAL_W-1:0] din_i,
    output logic [TOTAL_W-1:0] hold_q
);
    for (genvar k = 0; k < SLOTS; k++) begin : g_reg
        // capture field k of the incoming set
        always_ff @(posedge clk) begin
            if (!rst_n)
                hold_q[k*ID_W +: ID_W] <= '0;
            else if (cap_i)
                hold_q[k*ID_W +: ID_W] <= din_i[k*ID_W +: ID_W];
        end
    end
endmodule

// File: rtl/tag_out_mux.sv
// Module: tag_out_mux
// Combinational selector. Picks the holding register chosen by the slot index.
// Assumes: sel_i < SLOTS.
module tag_out_mux #(
    parameter int unsigned ID_W  = tag_serializer_pkg::TS_ID_W,
    parameter int unsigned SLOTS = tag_serializer_pkg::TS_SLOTS,
    localparam int unsigned SEL_W   = $clog2(SLOTS),
    localparam int unsigned TOTAL_W = ID_W * SLOTS
) (
    input  logic [SEL_W-1:0]   sel_i,
    input  logic [TOTAL_W-1:0] hold_i,
    output logic [ID_W-1:0]    dout_o
);
    // and-or selection across all slots
    always_comb begin
        dout_o = '0;
        for (int k = 0; k < SLOTS; k++) begin
            if (sel_i == SEL_W'(k))
                dout_o = dout_o | hold_i[k*ID_W +: ID_W];
        end
    end
endmodule

// File: rtl/tag_serializer.sv
// Module: tag_serializer
// Top level. Captures one set of sorted identifiers per read cycle and emits
// them one per clock, field 0 first.
// Assumes: the sorter raises load_i in the last slot when a set is ready.
module tag_serializer #(
    parameter int unsigned ID_W  = tag_serializer_pkg::TS_ID_W,
    parameter int unsigned SLOTS = tag_serializer_pkg::TS_SLOTS,
    localparam int unsigned SEL_W   = $clog2(SLOTS),
    localparam int unsigned TOTAL_W = ID_W * SLOTS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [TOTAL_W-1:0] id_set_i,
    output logic [ID_W-1:0]    ser_id_o,
    output logic               ser_vld_o,
    output logic [SEL_W-1:0]   slot_o
);
    logic               wrap;
    logic               cap;
    logic [TOTAL_W-1:0] hold_q;

    tag_sel_gen #(.SLOTS(SLOTS)) u_sel (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_q  (slot_o),
        .wrap_o (wrap)
    );

    // capture only at the read-cycle boundary
    assign cap = load_i & wrap;

    tag_hold_bank #(.ID_W(ID_W), .SLOTS(SLOTS)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_i  (cap),
        .din_i  (id_set_i),
        .hold_q (hold_q)
    );

    tag_out_mux #(.ID_W(ID_W), .SLOTS(SLOTS)) u_mux (
        .sel_i  (slot_o),
        .hold_i (hold_q),
        .dout_o (ser_id_o)
    );

    // mark a read cycle as fresh when its set was loaded at the wrap
    always_ff @(posedge clk) begin
        if (!rst_n)
            ser_vld_o <= 1'b0;
        else if (wrap)
            ser_vld_o <= load_i;
    end
endmodule

// File: rtl/tag_serializer_chk.sv
// Module: tag_serializer_chk
// Property checker, bound to tag_serializer.
// Assumes: inputs change away from the rising clock edge.
module tag_serializer_chk #(
    parameter int unsigned ID_W  = tag_serializer_pkg::TS_ID_W,
    parameter int unsigned SLOTS = tag_serializer_pkg::TS_SLOTS,
    localparam int unsigned SEL_W   = $clog2(SLOTS),
    localparam int unsigned TOTAL_W = ID_W * SLOTS
) (
    input logic               clk,
    input logic               rst_n,
    input logic               load_i,
    input logic [TOTAL_W-1:0] id_set_i,
    input logic [ID_W-1:0]    ser_id_o,
    input logic               ser_vld_o,
    input logic [SEL_W-1:0]   slot_o,
    input logic [TOTAL_W-1:0] hold_q
);
    localparam logic [SEL_W-1:0] LAST = SEL_W'(SLOTS - 1);

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!ser_vld_o && slot_o == '0 && ser_id_o == '0));

    a_r2_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> slot_o == (($past(slot_o) == LAST) ? '0 : $past(slot_o) + 1'b1));

    a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && slot_o != '0) |-> $stable(hold_q));

    a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(load_i) && $past(slot_o) == LAST)
            |-> (ser_vld_o && hold_q == $past(id_set_i) && ser_id_o == $past(id_set_i[ID_W-1:0])));

    a_r5_vld_steady: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && slot_o != '0) |-> $stable(ser_vld_o));

    a_r8_no_load_keep: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(load_i) && $past(slot_o) == LAST)
            |-> (!ser_vld_o && $stable(hold_q)));
endmodule

bind tag_serializer tag_serializer_chk #(.ID_W(ID_W), .SLOTS(SLOTS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load_i),
    .id_set_i  (id_set_i),
    .ser_id_o  (ser_id_o),
    .ser_vld_o (ser_vld_o),
    .slot_o    (slot_o),
    .hold_q    (hold_q)
);

// File: tb/tag_serializer_tb.sv
module tag_serializer_tb;
    localparam int ID_W  = 8;
    localparam int SLOTS = 4;
    localparam int TOTAL = ID_W * SLOTS;
    localparam int NCYC  = 640;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             load_i;
    logic [TOTAL-1:0] id_set_i;
    logic [ID_W-1:0]  ser_id_o;
    logic             ser_vld_o;
    logic [1:0]       slot_o;

    int  vecs = 0;
    int  errs = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    tag_serializer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load_i),
        .id_set_i  (id_set_i),
        .ser_id_o  (ser_id_o),
        .ser_vld_o (ser_vld_o),
        .slot_o    (slot_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ascending set for read cycle rc; the first two are the directed example
    function automatic logic [TOTAL-1:0] set_for(input int rc);
        logic [TOTAL-1:0] s;
        if (rc == 0) return {8'h24, 8'h18, 8'h0C, 8'h03};
        if (rc == 1) return {8'h30, 8'h20, 8'h10, 8'h04};
        for (int k = 0; k < SLOTS; k++)
            s[k*ID_W +: ID_W] = 8'((rc * 7) % 60 + k * (rc % 16 + 1));
        return s;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL R2 watchdog expired actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        int               exp_slot;
        bit               exp_vld;
        logic [TOTAL-1:0] exp_hold;
        int               rc;
        int               nrec;
        logic [ID_W-1:0]  rec [8];
        logic [ID_W-1:0]  ref6 [8];
        bit               ld;
        logic [TOTAL-1:0] id;

        ref6 = '{8'h03, 8'h0C, 8'h18, 8'h24, 8'h04, 8'h10, 8'h20, 8'h30};
        rst_n = 1'b0; load_i = 1'b1; id_set_i = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 vld", 32'(ser_vld_o), 0);
        chk("R1 slot", 32'(slot_o), 0);
        chk("R1 id", 32'(ser_id_o), 0);
        rst_n = 1'b1;
        exp_slot = 0; exp_vld = 1'b0; exp_hold = '0; rc = 0; nrec = 0;

        for (int c = 0; c < NCYC; c++) begin
            chk("R2 slot", 32'(slot_o), 32'(exp_slot));
            chk("R5 vld", 32'(ser_vld_o), 32'(exp_vld));
            if (exp_vld)
                chk("R4 R3 R7 id", 32'(ser_id_o), 32'(exp_hold[exp_slot*ID_W +: ID_W]));
            else
                chk("R8 R3 id", 32'(ser_id_o), 32'(exp_hold[exp_slot*ID_W +: ID_W]));
            if (ser_vld_o && nrec < 8) begin
                rec[nrec] = ser_id_o;
                nrec++;
            end
            if (exp_slot == SLOTS - 1) begin
                ld = (rc < 2) || (rc % 5 != 3);
                id = ld ? set_for(rc) : {4{8'(c * 91 + 5)}};
            end else begin
                ld = c[0];
                id = {8'(c * 13), 8'(c * 91), 8'(c * 57 + 1), 8'(c * 201 + 3)};
            end
            load_i = ld;
            id_set_i = id;
            if (exp_slot == SLOTS - 1) begin
                if (ld) begin
                    exp_hold = id;
                    exp_vld = 1'b1;
                end else begin
                    exp_vld = 1'b0;
                end
                rc++;
            end
            exp_slot = (exp_slot + 1) % SLOTS;
            @(negedge clk);
        end

        chk("R6 count", 32'(nrec), 8);
        for (int i = 0; i < 8; i++)
            chk("R6 order", 32'(rec[i]), 32'(ref6[i]));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule